// File: doc/BRIEF.md
# Configurable Boolean Gate Network

This block evaluates a small network of eight configurable logic gates over eight single-bit inputs. Each gate has four pins. Every pin carries its own enable bit, invert bit and source pointer, and each gate has a function code that selects its type: AND, OR, XOR, majority, a stateful set/reset latch, or a two-way select. A pin may read a block input or the result of any gate with a lower index. The whole chain therefore settles combinationally within one cycle, and gate order alone sets the evaluation order.

The block drives the live gate results and the post-inversion state of every pin, which an observer can use to display or capture the network. It also raises per-gate flags for an invalid function code, an illegal source pointer and an unusable pin-enable pattern. Only the set/reset gates hold state. A synchronous reset clears that state, and so does an explicit initialise request. Output delay timing and state capture are left to surrounding logic.

Top module: `bool_gate_net`

## Requirements
- R1: Function code 1 is AND: the result is 1 when every enabled pin is 1, and 0 when no pin is enabled. Code 2 is OR: the result is 1 when any enabled pin is 1. Code 3 is XOR: the result is 1 when an odd number of enabled pins are 1.
- R2: Source pointer values 0 to 7 select input bit `in_bits[ptr]`, and values 8 to 15 select the result of gate ptr-8. Results propagate through a chain of gates in the same cycle, with no clock edge. The pointer of pin p (p = 0 to 3, standing for pins 1 to 4) of gate g is `cfg_src[(p*8+g)*4 +: 4]`.
- R3: An enabled pin whose pointer names the gate itself or a higher-numbered gate sets `err_ptr[g]`, and its wire state reads 0 whatever its invert bit. A disabled pin never raises `err_ptr`.
- R4: When `cfg_inv[p*8+g]` is 1, the pin value is inverted before the gate uses it. The gate function ignores a pin whose `cfg_en[p*8+g]` is 0. The post-inversion state of pin p of gate g appears on `wire_live[p*8+g]` whether or not the pin is enabled.
- R5: Function codes 0 and 7 set `err_func[g]` and force the result of gate g to 0.
- R6: Code 4 is majority: the result is 1 for 2 of 2, 2 of 3, or 3 of 4 enabled pins true. With fewer than two pins enabled, the gate sets `err_mask[g]` and its result is 0.
- R7: Code 5 is set/reset. Pin 2 is a dominant reset, pin 1 is a dominant set, pin 4 is a reset and pin 3 is a set, and they take effect in that priority order. When both dominant pins are active the result is 0, and when only pin 3 and pin 4 are active the result is 0. A new result appears in the same cycle as the pin change. The result holds across clock edges while no enabled pin is active.
- R8: Code 6 is select: the result is pin 1 when pin 3 is 0, and pin 2 when pin 3 is 1. If pin 3 is disabled, or if pins 1 and 2 are both disabled, the gate sets `err_mask[g]` and its result is 0.
- R9: A set/reset gate's held state returns to 0 on the clock edge where `rst_n` is low or `init_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Clears set/reset gate state at the next edge |
| in_bits | input | 8 | Logic inputs, source pointers 0 to 7 |
| cfg_func | input | 24 | 3-bit function code per gate, gate g at bits [g*3 +: 3] |
| cfg_en | input | 32 | Pin enable, bit p*8+g |
| cfg_inv | input | 32 | Pin invert, bit p*8+g |
| cfg_src | input | 128 | 4-bit source pointer per pin, field (p*8+g)*4 |
| gate_live | output | 8 | Live gate results, bit g is gate g |
| wire_live | output | 32 | Post-inversion pin states, bit p*8+g |
| err_func | output | 8 | Invalid function code, per gate |
| err_ptr | output | 8 | Self or forward reference on an enabled pin, per gate |
| err_mask | output | 8 | Unusable enable pattern for majority or select, per gate |

## Verification
Every result except the held set/reset state is combinational. Inputs and configuration are therefore driven on the falling edge and sampled 2 ns later, before the next rising edge. A check made this way sees the result of the new stimulus and no register update. The holding behaviour and the two ways of clearing it appear only one rising edge later. Those checks drive the trigger on one falling edge, remove it on the next falling edge, and sample after that, so exactly one edge has stored or cleared the state.

// File: rtl/bgn_pkg.sv
// Package: shared constants and gate function encoding for the Boolean gate network.
// Assumes every gate has exactly four pins; the set/reset and select roles are tied to pin position.
package bgn_pkg;

    localparam int unsigned PINS = 4;
    localparam int unsigned FN_W = 3;

    typedef enum logic [FN_W-1:0] {
        FN_NONE = 3'd0,
        FN_AND  = 3'd1,
        FN_OR   = 3'd2,
        FN_XOR  = 3'd3,
        FN_MAJ  = 3'd4,
        FN_SR   = 3'd5,
        FN_SEL  = 3'd6,
        FN_BAD  = 3'd7
    } gate_fn_e;

endpackage

// File: rtl/bgn_pin_fetch.sv
// Module: fetches one gate pin from the available source vector and applies its inversion.
// Assumes avail holds inputs in the low bits and lower-numbered gate results above them.
// A pointer at or beyond LIMIT (the gate's own index or higher) is illegal and reads 0.
module bgn_pin_fetch #(
    parameter int unsigned SRC_N = 16,
    parameter int unsigned PTR_W = 4,
    parameter int unsigned LIMIT = 8
) (
    input  logic [SRC_N-1:0] avail,
    input  logic [PTR_W-1:0] ptr,
    input  logic             inv,
    input  logic             en,
    output logic             wire_val,
    output logic             ptr_err
);

    logic in_range;

    // Decide legality of the pointer, then select and invert the source.
    always_comb begin
        in_range = (int'(ptr) < int'(LIMIT));
        wire_val = in_range ? (avail[ptr] ^ inv) : 1'b0;
        ptr_err  = en & ~in_range;
    end

endmodule

// File: rtl/bgn_gate_cell.sv
// Module: evaluates one gate from its four post-inversion pin values and holds set/reset state.
// Assumes pin values are already inverted; disabled pins are masked here.
// Only a set/reset gate keeps state, cleared by synchronous reset or an initialise request.
module bgn_gate_cell
    import bgn_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_req,
    input  logic [FN_W-1:0] func,
    input  logic [PINS-1:0] en,
    input  logic [PINS-1:0] wire_in,
    output logic            res,
    output logic            err_func,
    output logic            err_mask
);

    logic [PINS-1:0] act;
    logic [2:0]      n_en;
    logic [2:0]      n_act;
    logic            sr_q;
    logic            sr_next;
    gate_fn_e        fn;

    // Count set bits of a pin vector.
    function automatic logic [2:0] popc(input logic [PINS-1:0] v);
        logic [2:0] c;
        c = '0;
        for (int i = 0; i < int'(PINS); i++) c = c + 3'(v[i]);
        return c;
    endfunction

    // Mask pins by enable and count them.
    always_comb begin
        fn    = gate_fn_e'(func);
        act   = en & wire_in;
        n_en  = popc(en);
        n_act = popc(act);
    end

    // Set/reset priority: dominant reset, dominant set, reset, set, else hold.
    always_comb begin
        if (act[1])      sr_next = 1'b0;
        else if (act[0]) sr_next = 1'b1;
        else if (act[3]) sr_next = 1'b0;
        else if (act[2]) sr_next = 1'b1;
        else             sr_next = sr_q;
    end

    // Gate function and configuration checks.
    always_comb begin
        res      = 1'b0;
        err_func = 1'b0;
        err_mask = 1'b0;
        case (fn)
            FN_AND: res = (en != '0) && (act == en);
            FN_OR:  res = |act;
            FN_XOR: res = ^act;
            FN_MAJ: begin
                err_mask = (n_en < 3'd2);
                res      = !err_mask && ({n_act, 1'b0} > {1'b0, n_en});
            end
            FN_SR:  res = sr_next;
            FN_SEL: begin
                err_mask = !en[2] || (en[1:0] == 2'b00);
                res      = !err_mask && (act[2] ? act[1] : act[0]);
            end
            default: err_func = 1'b1;
        endcase
    end

    // Hold set/reset state; clear on reset, initialise, or a non-latch function.
    always_ff @(posedge clk) begin
        if (!rst_n || init_req) sr_q <= 1'b0;
        else                    sr_q <= (fn == FN_SR) ? sr_next : 1'b0;
    end

    a_r5_bad_func_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err_func |-> !res);

    a_r6_maj_few_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_MAJ && n_en < 3'd2) |-> (err_mask && !res));

    a_r7_reset_dominant: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_SR && act[1]) |-> !res);

    a_r7_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(init_req) && $past(fn) == FN_SR && fn == FN_SR && act == '0)
        |-> (res == $past(res)));

    a_r8_sel_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_SEL && !en[2]) |-> (err_mask && !res));

    a_r9_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(init_req) && fn == FN_SR && act == '0) |-> !res);

endmodule

// File: rtl/bool_gate_net.sv
// Module: top of the configurable Boolean gate network.
// Builds a ripple chain: gate g sees the inputs and the results of gates 0..g-1.
// Assumes configuration is held steady by its owner; all results except set/reset state are combinational.
module bool_gate_net
    import bgn_pkg::*;
#(
    parameter  int unsigned N_IN    = 8,
    parameter  int unsigned N_GATES = 8,
    localparam int unsigned SRC_N   = N_IN + N_GATES,
    localparam int unsigned PTR_W   = $clog2(SRC_N),
    localparam int unsigned N_PINS  = PINS * N_GATES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      init_req,
    input  logic [N_IN-1:0]           in_bits,
    input  logic [N_GATES*FN_W-1:0]   cfg_func,
    input  logic [N_PINS-1:0]         cfg_en,
    input  logic [N_PINS-1:0]         cfg_inv,
    input  logic [N_PINS*PTR_W-1:0]   cfg_src,
    output logic [N_GATES-1:0]        gate_live,
    output logic [N_PINS-1:0]         wire_live,
    output logic [N_GATES-1:0]        err_func,
    output logic [N_GATES-1:0]        err_ptr,
    output logic [N_GATES-1:0]        err_mask
);

    for (genvar g = 0; g < int'(N_GATES); g++) begin : g_gate
        logic [SRC_N-1:0] avail;
        logic [PINS-1:0]  w;
        logic [PINS-1:0]  pe;
        logic [PINS-1:0]  en;
        logic             res;
        logic             ef;
        logic             em;

        // Sources visible to this gate: inputs plus results of lower gates.
        if (g == 0) begin : g_first
            assign avail = SRC_N'(in_bits);
        end else begin : g_next
            assign avail = g_gate[g-1].avail | (SRC_N'(g_gate[g-1].res) << (N_IN + g - 1));
        end

        for (genvar p = 0; p < int'(PINS); p++) begin : g_pin
            bgn_pin_fetch #(
                .SRC_N(SRC_N),
                .PTR_W(PTR_W),
                .LIMIT(N_IN + g)
            ) u_pin (
                .avail   (avail),
                .ptr     (cfg_src[(p*N_GATES+g)*PTR_W +: PTR_W]),
                .inv     (cfg_inv[p*N_GATES+g]),
                .en      (cfg_en[p*N_GATES+g]),
                .wire_val(w[p]),
                .ptr_err (pe[p])
            );
            assign en[p]                 = cfg_en[p*N_GATES+g];
            assign wire_live[p*N_GATES+g] = w[p];
        end

        bgn_gate_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .init_req(init_req),
            .func    (cfg_func[g*FN_W +: FN_W]),
            .en      (en),
            .wire_in (w),
            .res     (res),
            .err_func(ef),
            .err_mask(em)
        );

        assign gate_live[g] = res;
        assign err_func[g]  = ef;
        assign err_ptr[g]   = |pe;
        assign err_mask[g]  = em;
    end

endmodule

// File: tb/bool_gate_net_bench.sv
// Bench: directed scenarios for the Boolean gate network, one task each, self-checking.
module bool_gate_net_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_req = 1'b0;
    logic [7:0]   in_bits = '0;
    logic [23:0]  cfg_func = '0;
    logic [31:0]  cfg_en = '0;
    logic [31:0]  cfg_inv = '0;
    logic [127:0] cfg_src = '0;
    logic [7:0]   gate_live;
    logic [31:0]  wire_live;
    logic [7:0]   err_func;
    logic [7:0]   err_ptr;
    logic [7:0]   err_mask;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bool_gate_net u_bool_gate_net (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .in_bits(in_bits),
        .cfg_func(cfg_func), .cfg_en(cfg_en), .cfg_inv(cfg_inv), .cfg_src(cfg_src),
        .gate_live(gate_live), .wire_live(wire_live), .err_func(err_func),
        .err_ptr(err_ptr), .err_mask(err_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_clear();
        for (int g = 0; g < 8; g++) cfg_func[g*3 +: 3] = 3'd2;
        cfg_en = '0; cfg_inv = '0; cfg_src = '0;
    endtask

    task automatic set_fn(input int g, input int code);
        cfg_func[g*3 +: 3] = code[2:0];
    endtask

    task automatic set_pin(input int g, input int p, input bit e, input bit i, input int s);
        cfg_en[p*8+g]            = e;
        cfg_inv[p*8+g]           = i;
        cfg_src[(p*8+g)*4 +: 4]  = s[3:0];
    endtask

    // Drive inputs on the falling edge and sample 2 ns later.
    task automatic apply(input logic [7:0] v);
        @(negedge clk);
        in_bits = v;
        #2;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        chk("R5 reset all codes 0 err_func", 32'(err_func), 32'h0000_00FF);
        chk("R5 reset gate_live zero", 32'(gate_live), 32'h0);
        chk("R3 reset err_ptr zero", 32'(err_ptr), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        cfg_clear();
        set_fn(0, 1); set_pin(0, 0, 1, 0, 0); set_pin(0, 1, 1, 0, 1); set_pin(0, 2, 0, 1, 7);
        set_fn(1, 2); set_pin(1, 0, 1, 0, 2); set_pin(1, 1, 1, 0, 3); set_pin(1, 2, 1, 0, 4);
        set_fn(2, 3); set_pin(2, 0, 1, 0, 0); set_pin(2, 1, 1, 0, 1); set_pin(2, 2, 1, 0, 2);
        set_fn(3, 1); set_pin(3, 0, 1, 0, 8); set_pin(3, 1, 1, 1, 10);
        set_fn(7, 1);
        apply(8'h03);
        chk("R1 R2 and/or/xor/chain in=03", 32'(gate_live), 32'h09);
        chk("R4 inverted chained pin wire", 32'(wire_live[11]), 32'h1);
        chk("R4 disabled pin wire exported", 32'(wire_live[16]), 32'h1);
        apply(8'h07);
        chk("R1 R2 in=07", 32'(gate_live), 32'h07);
        apply(8'h04);
        chk("R1 R2 in=04", 32'(gate_live), 32'h06);
        apply(8'h18);
        chk("R1 or only in=18", 32'(gate_live), 32'h02);
        apply(8'hFF);
        chk("R1 xor three ones, empty AND", 32'(gate_live), 32'h07);
        chk("R3 no pointer errors", 32'(err_ptr), 32'h0);
    endtask

    task automatic t_pointer();
        cfg_clear();
        set_pin(0, 0, 1, 0, 0);
        set_pin(1, 0, 1, 1, 9);
        set_pin(1, 1, 1, 0, 8);
        set_pin(2, 0, 0, 0, 15);
        apply(8'h01);
        chk("R3 self reference flagged", 32'(err_ptr), 32'h02);
        chk("R3 bad pin reads 0", 32'(wire_live[1]), 32'h0);
        chk("R2 R3 legal pin still used", 32'(gate_live), 32'h03);
        apply(8'h00);
        chk("R3 bad pin 0 with inputs low", 32'(gate_live), 32'h00);
    endtask

    task automatic t_func_err();
        cfg_clear();
        set_fn(0, 7); set_pin(0, 0, 1, 0, 0);
        set_fn(7, 0); set_pin(7, 0, 1, 0, 0);
        apply(8'h01);
        chk("R5 bad codes flagged", 32'(err_func), 32'h81);
        chk("R5 bad codes force 0", 32'(gate_live), 32'h00);
    endtask

    task automatic t_majority();
        cfg_clear();
        set_fn(4, 4);
        set_pin(4, 0, 1, 0, 0); set_pin(4, 1, 1, 0, 1); set_pin(4, 2, 1, 0, 2);
        apply(8'h03); chk("R6 2 of 3", 32'(gate_live[4]), 32'h1);
        apply(8'h01); chk("R6 1 of 3", 32'(gate_live[4]), 32'h0);
        set_pin(4, 3, 1, 0, 3);
        apply(8'h07); chk("R6 3 of 4", 32'(gate_live[4]), 32'h1);
        apply(8'h03); chk("R6 2 of 4", 32'(gate_live[4]), 32'h0);
        set_pin(4, 2, 0, 0, 2); set_pin(4, 3, 0, 0, 3);
        apply(8'h03); chk("R6 2 of 2", 32'(gate_live[4]), 32'h1);
        apply(8'h01); chk("R6 1 of 2", 32'(gate_live[4]), 32'h0);
        set_pin(4, 1, 0, 0, 1);
        apply(8'h01);
        chk("R6 one pin mask error", 32'(err_mask), 32'h10);
        chk("R6 one pin result 0", 32'(gate_live[4]), 32'h0);
    endtask

    task automatic t_setreset();
        cfg_clear();
        set_fn(5, 5);
        set_pin(5, 0, 1, 0, 0); set_pin(5, 1, 1, 0, 1);
        set_pin(5, 2, 1, 0, 2); set_pin(5, 3, 1, 0, 3);
        apply(8'h04); chk("R7 set same cycle", 32'(gate_live[5]), 32'h1);
        apply(8'h00); chk("R7 hold after set", 32'(gate_live[5]), 32'h1);
        apply(8'h08); chk("R7 reset", 32'(gate_live[5]), 32'h0);
        apply(8'h00); chk("R7 hold after reset", 32'(gate_live[5]), 32'h0);
        apply(8'h05); chk("R7 dominant set", 32'(gate_live[5]), 32'h1);
        apply(8'h09); chk("R7 dominant set beats reset", 32'(gate_live[5]), 32'h1);
        apply(8'h03); chk("R7 dominant reset wins", 32'(gate_live[5]), 32'h0);
        apply(8'h06); chk("R7 dominant reset over set", 32'(gate_live[5]), 32'h0);
        apply(8'h04); apply(8'h0C); chk("R7 reset beats set", 32'(gate_live[5]), 32'h0);
        apply(8'h04); apply(8'h00);
        chk("R7 held before init", 32'(gate_live[5]), 32'h1);
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0; #2;
        chk("R9 init clears state", 32'(gate_live[5]), 32'h0);
        apply(8'h04); apply(8'h00);
        chk("R7 held before reset", 32'(gate_live[5]), 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #2;
        chk("R9 reset clears state", 32'(gate_live[5]), 32'h0);
    endtask

    task automatic t_select();
        cfg_clear();
        set_fn(6, 6);
        set_pin(6, 0, 1, 0, 0); set_pin(6, 1, 1, 0, 1); set_pin(6, 2, 1, 0, 2);
        apply(8'h01); chk("R8 pin3 low passes pin1", 32'(gate_live[6]), 32'h1);
        apply(8'h05); chk("R8 pin3 high passes pin2", 32'(gate_live[6]), 32'h0);
        apply(8'h06); chk("R8 pin3 high pin2 set", 32'(gate_live[6]), 32'h1);
        chk("R8 legal select no mask error", 32'(err_mask), 32'h0);
        set_pin(6, 2, 0, 0, 2);
        apply(8'h01);
        chk("R8 pin3 disabled flags", 32'(err_mask), 32'h40);
        chk("R8 mask error result 0", 32'(gate_live[6]), 32'h0);
        set_pin(6, 2, 1, 0, 2); set_pin(6, 0, 0, 0, 0); set_pin(6, 1, 0, 0, 1);
        apply(8'h01);
        chk("R8 data pins disabled flags", 32'(err_mask), 32'h40);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_pointer();
        t_func_err();
        t_majority();
        t_setreset();
        t_select();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule